// File: doc/BRIEF.md
# Selection and Interrupt Status Unit

This unit turns bus conditions and event strobes into the controller's interrupt request and its error status bits. It watches the synchronized select, busy and I/O lines together with the data-bus ID lines. It recognises a selection addressed to this device when three things hold at once: select is active, busy is idle, and at least one ID line matches a bit set in the select-enable register. That condition must then stay true for a settle window counted in clock cycles.

When the I/O line is active at the moment of recognition, the event is reported as a reselection. If the parity-check enable is set, a selection that arrives with a bus parity error is discarded. Other logic reports end-of-process, bus reset, phase mismatch, disconnection, data parity errors and busy loss as single-cycle strobes. Any of these also raises the interrupt. A status-clear read strobe or reset drops the interrupt and the error bits.

Top module: `sel_irq_status`

## Requirements
- R1: A selection event occurs only after the condition (select high, busy low, at least one ID match) has been true on SETTLE_CYC consecutive rising clock edges. `irq_o` is high right after the SETTLE_CYC-th such edge and is still low after SETTLE_CYC-1 edges.
- R2: A match on any one bit of `id_i & sel_en_i` is enough. With `sel_en_i` all zeros, a selection never raises `irq_o`.
- R3: When a selection is recognised, `resel_o` takes the value of `io_i` (1 = reselection, 0 = selection). It holds that value until the next recognised selection.
- R4: When `par_en_i` is 1 and `par_err_i` is 1 in the recognition cycle, the selection raises no interrupt. When `par_en_i` is 0, `par_err_i` has no effect.
- R5: Each of the strobes `eop_stb_i`, `busrst_stb_i`, `phase_stb_i`, `disc_stb_i`, `xpar_stb_i` and `bsy_loss_stb_i` sets `irq_o` on the next edge.
- R6: `xpar_stb_i` sets `par_err_o`, and `bsy_loss_stb_i` sets `busy_err_o`. Both bits are sticky.
- R7: `clr_i` clears `irq_o`, `par_err_o` and `busy_err_o` on the next edge. A setting event in the same cycle wins, and the bit stays set.
- R8: A selection interrupt fires at most once for each assertion of select. It can fire again only after select has gone low.
- R9: After reset, `irq_o`, `par_err_o`, `busy_err_o` and `resel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Synchronized select, 1 = active |
| bsy_i | input | 1 | Synchronized busy, 1 = active |
| io_i | input | 1 | Synchronized I/O, 1 = active |
| id_i | input | ID_W | Data-bus ID lines |
| par_err_i | input | 1 | Bus parity error indication |
| sel_en_i | input | ID_W | Select-enable register |
| par_en_i | input | 1 | Parity-check enable mode bit |
| eop_stb_i | input | 1 | End-of-process strobe |
| busrst_stb_i | input | 1 | Bus reset strobe |
| phase_stb_i | input | 1 | Phase mismatch strobe |
| disc_stb_i | input | 1 | Disconnect strobe |
| xpar_stb_i | input | 1 | Data-transfer parity error strobe |
| bsy_loss_stb_i | input | 1 | Busy loss strobe |
| clr_i | input | 1 | Status-clear read strobe |
| irq_o | output | 1 | Interrupt request, sticky level |
| par_err_o | output | 1 | Parity error status bit |
| busy_err_o | output | 1 | Busy error status bit |
| resel_o | output | 1 | Last recognised selection was a reselection |

## Verification
Random trials vary the hold length around SETTLE_CYC, the ID and enable patterns (including an all-zero enable), I/O, and the parity bits. These trials separate a counter that is off by one from a correct one. They also separate an any-bit match from an all-bits match and show that parity blocks a selection only when parity checking is enabled. Directed cases cover several things:
- holds of exactly SETTLE_CYC-1 and SETTLE_CYC edges;
- a long select hold that is cleared part-way, to show the interrupt does not fire twice;
- each strobe on its own;
- a clear that lands in the same cycle as an event.

// File: rtl/sel_irq_status.sv
module sel_irq_status #(
  parameter int ID_W       = 8,
  parameter int SETTLE_CYC = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_i,
  input  logic            bsy_i,
  input  logic            io_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            par_err_i,
  input  logic [ID_W-1:0] sel_en_i,
  input  logic            par_en_i,
  input  logic            eop_stb_i,
  input  logic            busrst_stb_i,
  input  logic            phase_stb_i,
  input  logic            disc_stb_i,
  input  logic            xpar_stb_i,
  input  logic            bsy_loss_stb_i,
  input  logic            clr_i,
  output logic            irq_o,
  output logic            par_err_o,
  output logic            busy_err_o,
  output logic            resel_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;
  logic          armed;

  wire sel_cond = sel_i & ~bsy_i & |(id_i & sel_en_i);
  wire sel_hit  = sel_cond & armed & (cnt == LAST);
  wire sel_ok   = sel_hit & ~(par_en_i & par_err_i);
  wire ext_ev   = eop_stb_i | busrst_stb_i | phase_stb_i | disc_stb_i
                | xpar_stb_i | bsy_loss_stb_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      armed      <= 1'b1;
      irq_o      <= 1'b0;
      par_err_o  <= 1'b0;
      busy_err_o <= 1'b0;
      resel_o    <= 1'b0;
    end else begin
      if (!sel_cond)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      if (!sel_i)           armed <= 1'b1;
      else if (sel_hit)     armed <= 1'b0;
      irq_o      <= sel_ok | ext_ev | (irq_o & ~clr_i);
      par_err_o  <= xpar_stb_i | (par_err_o & ~clr_i);
      busy_err_o <= bsy_loss_stb_i | (busy_err_o & ~clr_i);
      if (sel_ok) resel_o <= io_i;
    end
  end

  wire any_stb = eop_stb_i | busrst_stb_i | phase_stb_i | disc_stb_i
               | xpar_stb_i | bsy_loss_stb_i;

  AST_RISE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && !$past(any_stb)) |-> $past(sel_i && !bsy_i)); // R1
  AST_ZERO_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en_i == '0 && !any_stb && !irq_o) |=> !irq_o); // R2
  AST_PARITY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en_i && par_err_i && !any_stb && !irq_o) |=> !irq_o); // R4
  AST_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> irq_o); // R5
  AST_CLR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !any_stb && !sel_i) |=> !irq_o); // R7
  AST_CLR_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !xpar_stb_i) |=> !par_err_o); // R7
  AST_BERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_loss_stb_i |=> busy_err_o); // R6
endmodule

// File: tb/sim_sel_irq_status.sv
`timescale 1ns/1ps
module sim_sel_irq_status;
  localparam int ID_W = 8;
  localparam int S    = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_i = 0, bsy_i = 0, io_i = 0, par_err_i = 0, par_en_i = 0;
  logic [ID_W-1:0] id_i = '0, sel_en_i = '0;
  logic eop_stb_i = 0, busrst_stb_i = 0, phase_stb_i = 0, disc_stb_i = 0;
  logic xpar_stb_i = 0, bsy_loss_stb_i = 0, clr_i = 0;
  logic irq_o, par_err_o, busy_err_o, resel_o;

  int n_chk = 0, n_fail = 0;
  logic exp_resel = 0;

  always #2.5 clk = ~clk;

  sel_irq_status #(.ID_W(ID_W), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bsy_i(bsy_i), .io_i(io_i),
    .id_i(id_i), .par_err_i(par_err_i), .sel_en_i(sel_en_i), .par_en_i(par_en_i),
    .eop_stb_i(eop_stb_i), .busrst_stb_i(busrst_stb_i), .phase_stb_i(phase_stb_i),
    .disc_stb_i(disc_stb_i), .xpar_stb_i(xpar_stb_i), .bsy_loss_stb_i(bsy_loss_stb_i),
    .clr_i(clr_i), .irq_o(irq_o), .par_err_o(par_err_o), .busy_err_o(busy_err_o),
    .resel_o(resel_o));

  function automatic logic exp_fire(logic [ID_W-1:0] id, logic [ID_W-1:0] en,
                                    logic pe, logic perr, int hold);
    return (|(id & en)) && hold >= S && !(pe && perr);
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_i = 1; @(negedge clk); clr_i = 0; @(negedge clk);
  endtask

  task automatic sel_trial(logic [ID_W-1:0] id, logic [ID_W-1:0] en, logic io,
                           logic pe, logic perr, int hold);
    logic f;
    f = exp_fire(id, en, pe, perr, hold);
    id_i = id; sel_en_i = en; io_i = io; par_en_i = pe; par_err_i = perr;
    sel_i = 1; bsy_i = 0;
    repeat (hold) @(negedge clk);
    if (f) exp_resel = io;
    chk(irq_o, f, "R1/R2/R4 selection irq");
    chk(resel_o, exp_resel, "R3 resel flag");
    sel_i = 0; @(negedge clk);
    chk(irq_o, f, "R7 irq sticky until clear");
    clear_all();
    chk(irq_o, 1'b0, "R7 irq cleared");
  endtask

  task automatic strobe_one(int k);
    case (k)
      0: eop_stb_i = 1; 1: busrst_stb_i = 1; 2: phase_stb_i = 1;
      3: disc_stb_i = 1; 4: xpar_stb_i = 1; default: bsy_loss_stb_i = 1;
    endcase
    @(negedge clk);
    {eop_stb_i, busrst_stb_i, phase_stb_i, disc_stb_i, xpar_stb_i, bsy_loss_stb_i} = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(irq_o, 1'b0, "R9 reset irq");
    chk(par_err_o, 1'b0, "R9 reset par_err");
    chk(busy_err_o, 1'b0, "R9 reset busy_err");
    chk(resel_o, 1'b0, "R9 reset resel");
    rst_n = 1; @(negedge clk);

    sel_trial(8'h04, 8'h04, 1'b0, 1'b0, 1'b0, S - 1);  // R1 one short
    sel_trial(8'h04, 8'h04, 1'b1, 1'b0, 1'b0, S);      // R1 exact, R3 reselection
    sel_trial(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, S + 5);  // R2 zero enable
    sel_trial(8'h81, 8'h01, 1'b0, 1'b0, 1'b0, S);      // R2 single match, R3 selection
    sel_trial(8'h10, 8'h10, 1'b1, 1'b1, 1'b1, S + 2);  // R4 blocked
    sel_trial(8'h10, 8'h10, 1'b1, 1'b0, 1'b1, S + 2);  // R4 parity ignored

    for (int t = 0; t < 60; t++) begin
      logic [ID_W-1:0] id, en;
      id = ID_W'($urandom);
      en = ($urandom % 4 == 0) ? '0 : ID_W'($urandom);
      if ($urandom % 3 == 0) id = '0;
      sel_trial(id, en, 1'($urandom), 1'($urandom), 1'($urandom),
                S - 4 + int'($urandom % 9));
    end

    // R8: one fire per select assertion
    id_i = 8'h02; sel_en_i = 8'h02; io_i = 0; par_en_i = 0; par_err_i = 0;
    sel_i = 1;
    repeat (S) @(negedge clk);
    exp_resel = 0;
    chk(irq_o, 1'b1, "R8 first fire");
    clear_all();
    repeat (2 * S) @(negedge clk);
    chk(irq_o, 1'b0, "R8 no refire while sel held");
    sel_i = 0; @(negedge clk);
    sel_i = 1; repeat (S) @(negedge clk);
    chk(irq_o, 1'b1, "R8 refire after sel drop");
    sel_i = 0; clear_all();

    // R5/R6 strobes
    for (int k = 0; k < 6; k++) begin
      strobe_one(k);
      chk(irq_o, 1'b1, "R5 strobe sets irq");
      chk(par_err_o, k == 4, "R6 par_err from xpar only");
      chk(busy_err_o, k == 5, "R6 busy_err from bsy loss only");
      clear_all();
      chk(par_err_o, 1'b0, "R7 par_err cleared");
      chk(busy_err_o, 1'b0, "R7 busy_err cleared");
    end

    // R7: event and clear in the same cycle
    clr_i = 1; xpar_stb_i = 1; bsy_loss_stb_i = 1; @(negedge clk);
    clr_i = 0; xpar_stb_i = 0; bsy_loss_stb_i = 0;
    chk(irq_o, 1'b1, "R7 event beats clear irq");
    chk(par_err_o, 1'b1, "R7 event beats clear par_err");
    chk(busy_err_o, 1'b1, "R7 event beats clear busy_err");
    clear_all();
    chk(irq_o, 1'b0, "R7 final clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule